// File: doc/BRIEF.md
# Fold-Based Modulo-179 Reducer

This block returns the remainder of an unsigned 32-bit operand divided by the fixed modulus 179. It does not divide. The block uses the fact that 256 is congruent to 77 modulo 179. The operand is split into a low byte, which is kept in an accumulator, and a high part. The high part is then multiplied by 77 over and over. On each pass, the low byte of the product is added to the accumulator and the rest of the product becomes the next high part. When the high part reaches zero, whatever the accumulator holds above its low byte is split off and folded in again. Once the accumulator fits in one byte, a single conditional subtraction of 179 gives the exact remainder.

A client pulses `start` with the operand while `busy` is low. The block takes one fold step per clock and uses a single constant multiplier. It then raises `done` for one cycle, and the remainder appears on `result` in that same cycle. `result` keeps that value until the next operation completes.

Top module: `modfold_reducer`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `busy` is 0, `done` is 0 and `result` is 0.
- R2: For any 32-bit operand accepted by a start, the `result` presented with `done` equals the operand modulo 179.
- R3: The fixed corner operands give these results: 0 gives 0, 178 gives 178, 179 gives 0, 0x00C0FFEE gives 111, and 0xFFFFFFFF gives 4294967295 mod 179.
- R4: `done` is high for exactly one cycle per accepted start, and `busy` is low in that cycle.
- R5: `result` changes only in a cycle where `done` is high. It holds its value at all other times.
- R6: A `start` raised while `busy` is high is ignored. The running operation completes with the remainder of the operand captured at the accepted start, and no extra `done` pulse occurs.
- R7: `busy` is high in the cycle after an accepted start (a start with `busy` low).
- R8: `result` is always below 179.
- R9: `done` arrives no more than 48 cycles after the clock edge that accepted the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a reduction; accepted only while idle |
| operand | input | 32 | Unsigned value to reduce, captured on an accepted start |
| busy | output | 1 | High while a reduction is in progress |
| done | output | 1 | One-cycle pulse marking a valid `result` |
| result | output | 8 | Remainder modulo 179, held until the next completion |

## Verification
The directed operands test specific points in the reduction. Zero checks that the fold loop still terminates when there is nothing to fold. 178 and 179 sit on either side of the final subtraction. 0x00C0FFEE has a known answer, and 0xFFFFFFFF makes the inner loop run the most times and pushes the accumulator highest. Several hundred seeded random 32-bit operands are compared against a reference built on the `%` operator, and each one is also timed against the latency bound. A start raised in the middle of an operation, carrying a different operand, shows that the operand in flight is not replaced.

// File: rtl/modfold_pkg.sv
package modfold_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INNER = 2'd1,
    ST_OUTER = 2'd2,
    ST_FIN   = 2'd3
  } fold_state_e;
endpackage

// File: rtl/modfold_ctrl.sv
module modfold_ctrl
  import modfold_pkg::*;
#(
  parameter int MAX_LAT = 48
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        inner_q_zero,
  input  logic        outer_q_zero,
  output fold_state_e state,
  output logic        load,
  output logic        busy
);
  localparam int CW = $clog2(MAX_LAT + 2);

  fold_state_e state_nx;
  logic [CW-1:0] lat_cnt;

  assign busy = (state != ST_IDLE);
  assign load = start && (state == ST_IDLE);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (start) state_nx = ST_INNER;
      ST_INNER: if (inner_q_zero) state_nx = ST_OUTER;
      ST_OUTER: state_nx = outer_q_zero ? ST_FIN : ST_INNER;
      ST_FIN:   state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  // Cycles spent since the accepting edge; saturates above the bound.
  always_ff @(posedge clk) begin
    if (rst || load)                 lat_cnt <= '0;
    else if (busy && lat_cnt <= CW'(MAX_LAT)) lat_cnt <= lat_cnt + 1'b1;
  end

  assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_latency_bound_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (lat_cnt < CW'(MAX_LAT)));
endmodule

// File: rtl/modfold_datapath.sv
module modfold_datapath
  import modfold_pkg::*;
#(
  parameter int IN_W = 32,
  parameter int K    = 8,
  parameter int MOD  = 179
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [IN_W-1:0] operand,
  input  fold_state_e     state,
  output logic            inner_q_zero,
  output logic            outer_q_zero,
  output logic [K-1:0]    r_low
);
  localparam int FOLD = (1 << K) - MOD;
  localparam int PW   = IN_W + K;

  logic [IN_W-1:0] r_acc;
  logic [IN_W-1:0] q_hi;
  logic [PW-1:0]   prod;
  logic [IN_W-1:0] prod_hi;
  logic [K-1:0]    prod_lo;

  // Single multiply by the constant fold factor.
  assign prod    = PW'(q_hi) * PW'(FOLD);
  assign prod_lo = prod[K-1:0];
  assign prod_hi = prod[K +: IN_W];

  assign inner_q_zero = (prod_hi == '0);
  assign outer_q_zero = (r_acc[IN_W-1:K] == '0);
  assign r_low        = r_acc[K-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      r_acc <= '0;
      q_hi  <= '0;
    end else if (load) begin
      r_acc <= IN_W'(operand[K-1:0]);
      q_hi  <= operand >> K;
    end else begin
      case (state)
        ST_INNER: begin
          r_acc <= r_acc + IN_W'(prod_lo);
          q_hi  <= prod_hi;
        end
        ST_OUTER: begin
          q_hi  <= r_acc >> K;
          r_acc <= IN_W'(r_acc[K-1:0]);
        end
        default: ;
      endcase
    end
  end

  // Reduction must leave only one byte before the final correction (R2).
  assert_fold_settled_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIN) |-> (r_acc[IN_W-1:K] == '0));
endmodule

// File: rtl/modfold_final.sv
module modfold_final #(
  parameter int K   = 8,
  parameter int MOD = 179
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fin,
  input  logic [K-1:0] r_low,
  output logic         done,
  output logic [K-1:0] result
);
  localparam logic [K-1:0] MOD_C = K'(MOD);

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= fin;
      if (fin) result <= (r_low >= MOD_C) ? (r_low - MOD_C) : r_low;
    end
  end

  assert_result_range_R8: assert property (@(posedge clk) disable iff (rst)
    result < MOD_C);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

// File: rtl/modfold_reducer.sv
module modfold_reducer
  import modfold_pkg::*;
#(
  parameter int IN_W    = 32,
  parameter int K       = 8,
  parameter int MOD     = 179,
  parameter int MAX_LAT = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [IN_W-1:0] operand,
  output logic            busy,
  output logic            done,
  output logic [K-1:0]    result
);
  fold_state_e state;
  logic load, inner_q_zero, outer_q_zero;
  logic [K-1:0] r_low;

  modfold_ctrl #(.MAX_LAT(MAX_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .inner_q_zero(inner_q_zero), .outer_q_zero(outer_q_zero),
    .state(state), .load(load), .busy(busy)
  );

  modfold_datapath #(.IN_W(IN_W), .K(K), .MOD(MOD)) u_dp (
    .clk(clk), .rst(rst), .load(load), .operand(operand), .state(state),
    .inner_q_zero(inner_q_zero), .outer_q_zero(outer_q_zero), .r_low(r_low)
  );

  modfold_final #(.K(K), .MOD(MOD)) u_fin (
    .clk(clk), .rst(rst), .fin(state == ST_FIN), .r_low(r_low),
    .done(done), .result(result)
  );

  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/modfold_reducer_tb.sv
module modfold_reducer_tb;
  localparam int MAX_LAT = 48;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] operand = '0;
  logic        busy, done;
  logic [7:0]  result;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  modfold_reducer u_dut (
    .clk(clk), .rst(rst), .start(start), .operand(operand),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [7:0] ref_mod(input logic [31:0] v);
    return 8'(v % 32'd179);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // One operation; optionally fire a rejected start with another operand.
  task automatic run_op(input logic [31:0] op, input logic [31:0] intruder,
                        input bit intrude, input string req);
    int lat = 0;
    int dones = 0;
    logic [7:0] prev;
    @(negedge clk);
    prev = result;
    start = 1'b1; operand = op;
    @(negedge clk);
    start = 1'b0; operand = '0;
    lat = 1;
    check("R7 busy after start", busy, 1);
    if (intrude) begin
      start = 1'b1; operand = intruder;
    end
    while (!done && lat < 200) begin
      check("R5 result held while busy", result, prev);
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    check({req, " done seen"}, done, 1);
    check({req, " remainder"}, result, ref_mod(op));
    check("R4 busy low with done", busy, 0);
    check("R8 result below 179", result < 8'd179, 1);
    check("R9 latency", lat <= MAX_LAT, 1);
    prev = result;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check("R4 single done pulse / R6 no extra done", dones, 0);
    check("R5 result held after done", result, prev);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    check("R1 result in reset", result, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 result after reset", result, 0);

    run_op(32'd0,          0, 0, "R3 zero");
    run_op(32'd178,        0, 0, "R3 178");
    run_op(32'd179,        0, 0, "R3 179");
    run_op(32'h00C0FFEE,   0, 0, "R3 c0ffee");
    check("R3 c0ffee literal", result, 111);
    run_op(32'hFFFFFFFF,   0, 0, "R3 all ones");
    run_op(32'd357,        0, 0, "R2 357");
    run_op(32'd358,        0, 0, "R2 358");
    run_op(32'd1000, 32'hFFFFFFFF, 1, "R6 start ignored while busy");
    run_op(32'h12345678, 32'd5, 1, "R6 second ignore");

    for (int n = 0; n < 300; n++) begin
      run_op($urandom(), 0, 0, "R2 random");
    end
    summary();
  end
endmodule